// File: doc/BRIEF.md
# HDLC Receive Byte Queue with Maskable Interrupts

This block sits between a serial HDLC receiver and a host register interface. The receiver pushes bytes, each tagged with an end-of-packet marker. The host pops them in arrival order from a 16-entry queue. The current head entry, data plus tag, is always visible on the read port, and a pop advances the queue by one entry.

The block raises five sticky status conditions:
- a write was refused because the queue was full;
- the fill level crossed a programmable threshold;
- an end-of-packet byte was accepted;
- an end-of-packet byte reached the head, or the host read while the queue was empty;
- the go-ahead bit pattern was seen on the incoming serial stream.

The host clears each status bit by writing a one to its position. A mask with one bit per status decides which of them can drive the single interrupt output.

Status bit positions are fixed as follows: bit 0 overflow, bit 1 threshold, bit 2 end-of-packet written, bit 3 end-of-packet at head, bit 4 go-ahead.

Top module: `hdlc_rx_fifo_irq`

## Requirements
- R1: After reset the queue is empty, `rd_data` and `rd_eop` read 0, every bit of `irq_status` is 0 and `irq` is 0.
- R2: Accepted bytes leave in the order they were written. `rd_data`/`rd_eop` always show the head entry, and a pulse on `rd_en` moves to the next entry. The queue stores up to 16 entries.
- R3: A write while 16 entries are held is discarded, leaves the stored contents unchanged, and sets status bit 0 at the clock edge of that write.
- R4: Status bit 1 is set at the edge where the fill count goes from at most `full_thresh` to above it. The count used is the one after that edge's write and read.
- R5: Status bit 2 is set at the edge where a byte with `wr_eop`=1 is accepted into the queue.
- R6: Status bit 3 is set at the edge where an entry tagged end-of-packet becomes the head, either by a pop or by a write into an empty queue. An end-of-packet entry queued behind others does not set it.
- R7: A pop while the queue is empty sets status bit 3 and no other bit. It reads data 0 with tag 0 and leaves the queue contents and order unchanged.
- R8: Status bit 4 is set at the edge where the last eight `rx_bit` values sampled with `rx_bit_valid`, oldest first, are 0,1,1,1,1,1,1,1.
- R9: Status bits stay set until the host pulses `stat_clr_en` with a 1 in that position of `stat_clr`. Other bits are untouched, and a new set event in the same cycle wins over the clear.
- R10: `irq` is 1 exactly when some status bit is 1 and its `irq_mask` bit is 0. A mask bit of 1 blocks that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Push request from the receiver |
| wr_data | input | 8 | Byte to push |
| wr_eop | input | 1 | Byte is the last of its packet |
| rx_bit_valid | input | 1 | Serial bit strobe |
| rx_bit | input | 1 | Serial receive bit |
| rd_en | input | 1 | Host pop request |
| rd_data | output | 8 | Head byte (0 when empty) |
| rd_eop | output | 1 | Head byte end-of-packet tag |
| full_thresh | input | 4 | Fill threshold |
| irq_mask | input | 5 | Per-status mask, 1 blocks |
| stat_clr_en | input | 1 | Write-one-to-clear strobe |
| stat_clr | input | 5 | Bits to clear |
| irq_status | output | 5 | Sticky status bits |
| irq | output | 1 | Combined interrupt |

## Verification
A read or write pointer that slips shows up as wrong or reordered bytes on `rd_data` at the very next pop. A fill count that drifts shows up in the cycle after the wrong edge as one of three errors: an overflow flag that fires early, an overflow flag that never fires, or a threshold flag on the wrong write. A wrong head-tag path shows up as status bit 3 set one entry early or late, which can be seen in the cycle after the pop. A wrong alignment in the serial shift register sets the go-ahead flag one bit early or one bit late.

// File: rtl/hdlc_rx_fifo_irq.sv
module hdlc_rx_fifo_irq #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int NSRC  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_eop,
  input  logic          rx_bit_valid,
  input  logic          rx_bit,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_eop,
  input  logic [AW-1:0] full_thresh,
  input  logic [NSRC-1:0] irq_mask,
  input  logic          stat_clr_en,
  input  logic [NSRC-1:0] stat_clr,
  output logic [NSRC-1:0] irq_status,
  output logic          irq
);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW-1:0] rd_ptr_inc;
  logic [CW-1:0] fill, fill_nx, thr_ext;
  logic          wr_acc, rd_acc, empty_rd, ovf_ev;
  logic          head_eop_ev, thr_ev, ga_ev;
  logic [7:0]    ga_sr, ga_nx;
  logic [NSRC-1:0] set_ev, clr_vec;

  assign wr_acc     = wr_en && (fill != FULL);
  assign ovf_ev     = wr_en && (fill == FULL);
  assign rd_acc     = rd_en && (fill != '0);
  assign empty_rd   = rd_en && (fill == '0);
  assign rd_ptr_inc = rd_ptr + 1'b1;
  assign fill_nx    = fill + CW'(wr_acc) - CW'(rd_acc);
  assign thr_ext    = {1'b0, full_thresh};
  assign thr_ev     = (fill_nx > thr_ext) && (fill <= thr_ext);

  assign rd_data = (fill == '0) ? '0 : mem[rd_ptr][DW-1:0];
  assign rd_eop  = (fill != '0) && mem[rd_ptr][DW];

  always_comb begin
    head_eop_ev = 1'b0;
    if (rd_acc) begin
      if (fill > CW'(1))
        head_eop_ev = mem[rd_ptr_inc][DW];
      else if (wr_acc)
        head_eop_ev = wr_eop;
    end else if ((fill == '0) && wr_acc) begin
      head_eop_ev = wr_eop;
    end
  end

  assign ga_nx = {ga_sr[6:0], rx_bit};
  assign ga_ev = rx_bit_valid && (ga_nx == 8'h7F);

  assign set_ev  = {ga_ev, head_eop_ev || empty_rd, wr_acc && wr_eop, thr_ev, ovf_ev};
  assign clr_vec = stat_clr_en ? stat_clr : '0;

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wr_ptr] <= {wr_eop, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      fill       <= '0;
      ga_sr      <= 8'hFF;
      irq_status <= '0;
    end else begin
      if (wr_acc) wr_ptr <= wr_ptr + 1'b1;
      if (rd_acc) rd_ptr <= rd_ptr_inc;
      fill <= fill_nx;
      if (rx_bit_valid) ga_sr <= ga_nx;
      irq_status <= (irq_status & ~clr_vec) | set_ev;
    end
  end

  assign irq = |(irq_status & ~irq_mask);
endmodule

// File: rtl/hdlc_rx_fifo_irq_chk.sv
module hdlc_rx_fifo_irq_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int NSRC  = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            wr_eop,
  input logic            rd_en,
  input logic [NSRC-1:0] irq_mask,
  input logic            stat_clr_en,
  input logic [NSRC-1:0] irq_status,
  input logic            irq,
  input logic [AW:0]     fill
);
  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fill == (AW+1)'(DEPTH)) |=> irq_status[0]); // R3
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && fill == (AW+1)'(DEPTH)) |=> (fill == (AW+1)'(DEPTH))); // R3
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en) |=> $stable(fill)); // R2
  AST_EOPD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_eop && fill != (AW+1)'(DEPTH)) |=> irq_status[2]); // R5
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && fill == '0) |=> irq_status[3]); // R7
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_clr_en) |=> ((irq_status & $past(irq_status)) == $past(irq_status))); // R9
  AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&irq_mask) |-> !irq); // R10
endmodule

bind hdlc_rx_fifo_irq hdlc_rx_fifo_irq_chk #(.DEPTH(DEPTH), .AW(AW), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_eop(wr_eop), .rd_en(rd_en),
  .irq_mask(irq_mask), .stat_clr_en(stat_clr_en), .irq_status(irq_status),
  .irq(irq), .fill(fill)
);

// File: tb/tb_hdlc_rx_fifo_irq.sv
module tb_hdlc_rx_fifo_irq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_eop = 0, rx_bit_valid = 0, rx_bit = 0, rd_en = 0, stat_clr_en = 0;
  logic [7:0] wr_data = '0;
  logic [3:0] full_thresh = 4'd15;
  logic [4:0] irq_mask = 5'h1F, stat_clr = '0;
  logic [7:0] rd_data;
  logic rd_eop, irq;
  logic [4:0] irq_status;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_fifo_irq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_eop(wr_eop),
    .rx_bit_valid(rx_bit_valid), .rx_bit(rx_bit), .rd_en(rd_en),
    .rd_data(rd_data), .rd_eop(rd_eop), .full_thresh(full_thresh),
    .irq_mask(irq_mask), .stat_clr_en(stat_clr_en), .stat_clr(stat_clr),
    .irq_status(irq_status), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic e);
    wr_en = 1; wr_data = d; wr_eop = e;
    @(negedge clk);
    wr_en = 0; wr_eop = 0;
  endtask

  task automatic pop();
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic pop_chk(input string req, input logic [7:0] d, input logic e);
    chk(req, {rd_eop, rd_data}, {e, d});
    pop();
  endtask

  task automatic clr(input logic [4:0] m);
    stat_clr_en = 1; stat_clr = m;
    @(negedge clk);
    stat_clr_en = 0; stat_clr = '0;
  endtask

  task automatic send_bit(input logic b);
    rx_bit_valid = 1; rx_bit = b;
    @(negedge clk);
    rx_bit_valid = 0;
  endtask

  task automatic t_reset();
    chk("R1 status", irq_status, 0);
    chk("R1 irq", irq, 0);
    chk("R1 data", {rd_eop, rd_data}, 0);
  endtask

  task automatic t_order();
    push(8'hA1, 0); push(8'hB2, 0); push(8'hC3, 1);
    pop_chk("R2 first", 8'hA1, 0);
    pop_chk("R2 second", 8'hB2, 0);
    pop_chk("R2 third", 8'hC3, 1);
    clr(5'h1F);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 16; i++) push(8'(i + 8'h10), 0);
    chk("R3 no ovf at 16", int'(irq_status[0]), 0);
    push(8'hEE, 0);
    chk("R3 ovf set", int'(irq_status[0]), 1);
    for (int i = 0; i < 16; i++) pop_chk("R3 contents", 8'(i + 8'h10), 0);
    chk("R3 empty after drain", {rd_eop, rd_data}, 0);
    clr(5'h1F);
  endtask

  task automatic t_thresh();
    full_thresh = 4'd3;
    push(8'h01, 0); push(8'h02, 0); push(8'h03, 0);
    chk("R4 at threshold", int'(irq_status[1]), 0);
    push(8'h04, 0);
    chk("R4 above threshold", int'(irq_status[1]), 1);
    for (int i = 0; i < 4; i++) pop();
    clr(5'h1F);
    full_thresh = 4'd15;
    for (int i = 0; i < 15; i++) push(8'(i), 0);
    chk("R4 fifteen of thr 15", int'(irq_status[1]), 0);
    push(8'h5A, 0);
    chk("R4 sixteen of thr 15", int'(irq_status[1]), 1);
    for (int i = 0; i < 16; i++) pop();
    clr(5'h1F);
  endtask

  task automatic t_eop();
    push(8'h31, 0);
    chk("R5 plain byte", int'(irq_status[2]), 0);
    push(8'h32, 1);
    chk("R5 eop written", int'(irq_status[2]), 1);
    chk("R6 eop not at head", int'(irq_status[3]), 0);
    pop_chk("R6 head", 8'h31, 0);
    chk("R6 eop reaches head", int'(irq_status[3]), 1);
    pop_chk("R6 eop byte", 8'h32, 1);
    clr(5'h1F);
    push(8'h44, 1);
    chk("R6 eop into empty", int'(irq_status[3]), 1);
    pop();
    clr(5'h1F);
  endtask

  task automatic t_empty_read();
    pop();
    chk("R7 only bit3", irq_status, 5'h08);
    chk("R7 zero data", {rd_eop, rd_data}, 0);
    push(8'h77, 0);
    pop_chk("R7 pointers kept", 8'h77, 0);
    chk("R7 empty again", {rd_eop, rd_data}, 0);
    clr(5'h1F);
  endtask

  task automatic t_goahead();
    send_bit(1); send_bit(1); send_bit(0);
    for (int i = 0; i < 6; i++) send_bit(1);
    chk("R8 six ones", int'(irq_status[4]), 0);
    send_bit(1);
    chk("R8 pattern", int'(irq_status[4]), 1);
    clr(5'h1F);
    send_bit(1);
    chk("R8 eight ones", int'(irq_status[4]), 0);
  endtask

  task automatic t_w1c();
    pop();
    push(8'h90, 1);
    chk("R9 two bits", irq_status, 5'h0C);
    clr(5'h08);
    chk("R9 selective clear", irq_status, 5'h04);
    wr_en = 1; wr_data = 8'h91; wr_eop = 1; stat_clr_en = 1; stat_clr = 5'h04;
    @(negedge clk);
    wr_en = 0; wr_eop = 0; stat_clr_en = 0; stat_clr = '0;
    chk("R9 set beats clear", int'(irq_status[2]), 1);
    pop(); pop();
    clr(5'h1F);
    chk("R9 all cleared", irq_status, 0);
  endtask

  task automatic t_irq();
    push(8'h55, 1);
    irq_mask = 5'h1F; #1;
    chk("R10 all masked", irq, 0);
    irq_mask = 5'h1B; #1;
    chk("R10 bit2 open", irq, 1);
    irq_mask = 5'h04; #1;
    chk("R10 bit2 blocked", irq, 1);
    irq_mask = 5'h0C; #1;
    chk("R10 set bits blocked", irq, 0);
    pop();
    clr(5'h1F); #1;
    irq_mask = 5'h00; #1;
    chk("R10 nothing set", irq, 0);
    irq_mask = 5'h1F;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_order();
    t_overflow();
    t_thresh();
    t_eop();
    t_empty_read();
    t_goahead();
    t_w1c();
    t_irq();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule